// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block is a hardware state machine that switches a small set of power domains on or off, one domain at a time, in a fixed order of steps. Each domain is described by parameters. A domain may have a sleep control bit and an isolation bit. It has a list of memory power-down fields, given as register/mask pairs. It may also have a reset line and a clock enable. The block holds the sleep register, the isolation register and the memory power-down registers itself, and drives them out as plain vectors. The switch fabric and the memories read these vectors.

A request carries a direction (on or off) and a domain number. The block steps through its sequence and waits a set number of microseconds between the main steps. A prescaler turns the input clock into a one-microsecond tick, and these delays count that tick. When the sequence ends, the block pulses a done flag. A per-domain status output shows which domains are powered.

Top module: `pd_sequencer`

## Requirements
- R1: After reset, every sleep bit, isolation bit and memory power-down mask bit of every configured domain is 1. All other register bits are 0. Clock enables and domain resets are 0, and busy, done and err are 0.
- R2: An off request accepted at clock edge t0 sets the domain's sleep bit at edge t0+1. Its N memory entries are applied one per edge, starting at edge t0+2+S and ending at Em=t0+1+S+N. The isolation bit is set at edge Em+S+1. Here S = SHORT_US*CLK_PER_US.
- R3: On an off request, a domain that owns a clock drops its clock enable at edge Em+S+2+L, where L = LONG_US*CLK_PER_US, and done follows in the same cycle. A domain without a clock signals done at Em+S+2.
- R4: An on request clears the sleep bit and the memory fields with the same timing as R2. It then asserts the domain reset at Em+S+1, clears isolation at Em+S+2, releases the reset at Em+S+3, and raises the clock enable and done at Em+S+4.
- R5: A domain declared without a reset never drives its reset line. A domain without a clock never drives its clock enable. A memory-only domain never changes any sleep or isolation bit, but it keeps the same waits.
- R6: Each memory entry is a read-modify-write. On off it ORs the mask into its register, and on on it clears the masked bits. Bits outside the domain's masks, including other domains' fields, keep their value.
- R7: A domain's isolation bit sits either in the sleep register (the shared flag is set, for example sleep bit 8 and isolation bit 9) or at its own position in the separate isolation register.
- R8: pwr_on_o[d] is the inverse of the domain's sleep bit when the domain has one. For a memory-only domain it is 1 exactly when all bits of its first memory mask are 0.
- R9: A request with req_id_i >= NUM_DOM pulses err_o in the cycle after the edge that sampled it. It starts no sequence and changes no register.
- R10: A request while busy_o is high is ignored. No second sequence runs and no register of the named domain changes.
- R11: busy_o is high from the accepting edge until the cycle after done. done_o is high for exactly one cycle per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled when idle |
| req_on_i | input | 1 | 1 = power on, 0 = power off |
| req_id_i | input | IDW | Domain number |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |
| err_o | output | 1 | One-cycle pulse for an out-of-range domain number |
| sleep_o | output | 32 | Sleep control register |
| iso_o | output | 32 | Isolation control register |
| mem_pd_o | output | MEM_REGS*32 | Memory power-down registers, register r at bits [32r+31:32r] |
| dom_rst_o | output | NUM_DOM | Per-domain reset, active high |
| clk_en_o | output | NUM_DOM | Per-domain clock enable |
| pwr_on_o | output | NUM_DOM | Per-domain powered status |

## Verification
The bench stamps the exact cycle of every sleep, memory, isolation, reset, clock and done transition. It compares each stamp with the cycle computed from the step timing. A wrong prescaler or an off-by-one in a wait therefore shows up as a shifted stamp, not only as a wrong final value. Each domain variant is swept in both directions: the shared isolation bit with reset and clock, the separate isolation register, and the memory-only domain. This exposes a design that swaps the reset and isolation steps, gates the clock before the long wait, or touches sleep for a memory-only domain. A full-register comparison catches a read-modify-write that clobbers neighbouring fields. Out-of-range and busy-time requests are checked to leave every register and the done count untouched.

// File: rtl/pd_sequencer.sv
module pd_sequencer #(
  parameter int NUM_DOM    = 3,
  parameter int IDW        = 2,
  parameter int MEM_REGS   = 2,
  parameter int MEM_N      = 6,
  parameter int CLK_PER_US = 100,
  parameter int SHORT_US   = 20,
  parameter int LONG_US    = 20000,
  parameter logic [NUM_DOM-1:0]   HAS_TOP    = 3'b011,
  parameter logic [NUM_DOM-1:0]   ISO_SHARED = 3'b001,
  parameter logic [NUM_DOM-1:0]   HAS_RST    = 3'b001,
  parameter logic [NUM_DOM-1:0]   HAS_CLK    = 3'b001,
  parameter logic [NUM_DOM*5-1:0] SLP_POS    = {5'd0, 5'd16, 5'd8},
  parameter logic [NUM_DOM*5-1:0] ISO_POS    = {5'd0, 5'd16, 5'd9},
  parameter logic [NUM_DOM*8-1:0] MEM_FIRST  = {8'd5, 8'd3, 8'd0},
  parameter logic [NUM_DOM*8-1:0] MEM_CNT    = {8'd1, 8'd2, 8'd3},
  parameter logic [MEM_N*8-1:0]   ENT_REG    = {8'd0, 8'd0, 8'd1, 8'd1, 8'd0, 8'd0},
  parameter logic [MEM_N*32-1:0]  ENT_MASK   = {32'h0000_0030, 32'h3000_0000, 32'hC000_0000,
                                                32'h0000_00FF, 32'h0000_000C, 32'h0000_0003}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     req_on_i,
  input  logic [IDW-1:0]           req_id_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     err_o,
  output logic [31:0]              sleep_o,
  output logic [31:0]              iso_o,
  output logic [MEM_REGS*32-1:0]   mem_pd_o,
  output logic [NUM_DOM-1:0]       dom_rst_o,
  output logic [NUM_DOM-1:0]       clk_en_o,
  output logic [NUM_DOM-1:0]       pwr_on_o
);

  localparam int RIW = (MEM_REGS > 1) ? $clog2(MEM_REGS) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_TOP, S_W1, S_MEM, S_W2, S_RSTA, S_ISO, S_RSTD, S_W3, S_CLK, S_FIN
  } st_t;

  function automatic logic [31:0] mem_rst(int r);
    logic [31:0] v;
    v = '0;
    for (int e = 0; e < MEM_N; e++)
      if (int'(ENT_REG[e*8 +: 8]) == r) v = v | ENT_MASK[e*32 +: 32];
    return v;
  endfunction

  function automatic logic [31:0] slp_rst();
    logic [31:0] v;
    v = '0;
    for (int d = 0; d < NUM_DOM; d++)
      if (HAS_TOP[d]) begin
        v[SLP_POS[d*5 +: 5]] = 1'b1;
        if (ISO_SHARED[d]) v[ISO_POS[d*5 +: 5]] = 1'b1;
      end
    return v;
  endfunction

  function automatic logic [31:0] iso_rst();
    logic [31:0] v;
    v = '0;
    for (int d = 0; d < NUM_DOM; d++)
      if (HAS_TOP[d] && !ISO_SHARED[d]) v[ISO_POS[d*5 +: 5]] = 1'b1;
    return v;
  endfunction

  st_t                st_q;
  logic               on_q, err_q;
  logic [IDW-1:0]     id_q;
  logic [7:0]         idx_q;
  logic [31:0]        pre_q, us_q;
  logic [31:0]        slp_q, iso_q;
  logic [31:0]        mem_q [MEM_REGS];
  logic [NUM_DOM-1:0] rst_q, clk_q;

  logic [4:0]     spos, ipos;
  logic           top, shared, rstdom, clkdom, in_wait, tick, wait_end, mem_last;
  logic [7:0]     last_idx;
  logic [RIW-1:0] ereg;
  logic [31:0]    emask;
  int             wait_len;

  assign spos     = SLP_POS[id_q*5 +: 5];
  assign ipos     = ISO_POS[id_q*5 +: 5];
  assign top      = HAS_TOP[id_q];
  assign shared   = ISO_SHARED[id_q];
  assign rstdom   = HAS_RST[id_q];
  assign clkdom   = HAS_CLK[id_q];
  assign last_idx = MEM_FIRST[id_q*8 +: 8] + MEM_CNT[id_q*8 +: 8] - 8'd1;
  assign mem_last = (idx_q == last_idx);
  assign ereg     = RIW'(ENT_REG[idx_q*8 +: 8]);
  assign emask    = ENT_MASK[idx_q*32 +: 32];
  assign wait_len = (st_q == S_W3) ? LONG_US : SHORT_US;
  assign in_wait  = (st_q == S_W1) || (st_q == S_W2) || (st_q == S_W3);
  assign tick     = (pre_q == 32'(CLK_PER_US - 1));
  assign wait_end = in_wait && tick && (us_q == 32'(wait_len - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (!in_wait || wait_end) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (tick) begin
      pre_q <= '0;
      us_q  <= us_q + 32'd1;
    end else begin
      pre_q <= pre_q + 32'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      on_q  <= 1'b0;
      id_q  <= '0;
      idx_q <= '0;
      err_q <= 1'b0;
      slp_q <= slp_rst();
      iso_q <= iso_rst();
      rst_q <= '0;
      clk_q <= '0;
      for (int r = 0; r < MEM_REGS; r++) mem_q[r] <= mem_rst(r);
    end else begin
      err_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_i) begin
          if (32'(req_id_i) >= 32'(NUM_DOM)) err_q <= 1'b1;
          else begin
            on_q  <= req_on_i;
            id_q  <= req_id_i;
            idx_q <= MEM_FIRST[req_id_i*8 +: 8];
            st_q  <= S_TOP;
          end
        end
        S_TOP: begin
          if (top) slp_q[spos] <= ~on_q;
          st_q <= S_W1;
        end
        S_W1: if (wait_end) st_q <= S_MEM;
        S_MEM: begin
          mem_q[ereg] <= on_q ? (mem_q[ereg] & ~emask) : (mem_q[ereg] | emask);
          idx_q <= idx_q + 8'd1;
          if (mem_last) st_q <= S_W2;
        end
        S_W2: if (wait_end) st_q <= on_q ? S_RSTA : S_ISO;
        S_RSTA: begin
          if (rstdom) rst_q[id_q] <= 1'b1;
          st_q <= S_ISO;
        end
        S_ISO: begin
          if (top) begin
            if (shared) slp_q[ipos] <= ~on_q;
            else        iso_q[ipos] <= ~on_q;
          end
          st_q <= on_q ? S_RSTD : (clkdom ? S_W3 : S_CLK);
        end
        S_RSTD: begin
          if (rstdom) rst_q[id_q] <= 1'b0;
          st_q <= S_CLK;
        end
        S_W3: if (wait_end) st_q <= S_CLK;
        S_CLK: begin
          if (clkdom) clk_q[id_q] <= on_q;
          st_q <= S_FIN;
        end
        S_FIN: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = (st_q == S_FIN);
  assign err_o     = err_q;
  assign sleep_o   = slp_q;
  assign iso_o     = iso_q;
  assign dom_rst_o = rst_q;
  assign clk_en_o  = clk_q;

  for (genvar r = 0; r < MEM_REGS; r++) begin : g_mem
    assign mem_pd_o[r*32 +: 32] = mem_q[r];
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_stat
    localparam int FE = int'(MEM_FIRST[d*8 +: 8]);
    localparam int RG = int'(ENT_REG[FE*8 +: 8]);
    localparam logic [31:0] MK = ENT_MASK[FE*32 +: 32];
    if (HAS_TOP[d]) begin : g_top
      assign pwr_on_o[d] = ~slp_q[SLP_POS[d*5 +: 5]];
    end else begin : g_memonly
      assign pwr_on_o[d] = ((mem_q[RG] & MK) == 32'd0);
    end
  end

  logic iso_now;
  assign iso_now = shared ? slp_q[ipos] : iso_q[ipos];

  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> ($stable(id_q) && $stable(on_q)));
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R4
  rst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (dom_rst_o == '0));
  // R9
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
  // R4
  clk_after_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_CLK && on_q && top) |-> !iso_now);
  // R2
  mem_after_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_MEM && top) |-> (slp_q[spos] == !on_q));

endmodule

// File: tb/pd_sequencer_bench.sv
`timescale 1ns/1ps
module pd_sequencer_bench;
  localparam int P = 2, SU = 3, LU = 5;
  localparam int SP = P*SU, LP = P*LU;
  localparam logic [2:0] B_TOP = 3'b011, B_SH = 3'b001, B_RST = 3'b001, B_CLK = 3'b001;
  localparam int SPOS [3] = '{8, 16, 0};
  localparam int IPOS [3] = '{9, 16, 0};
  localparam int FIRST [3] = '{0, 3, 5};
  localparam int CNT [3] = '{3, 2, 1};
  localparam int EREG [6] = '{0, 0, 1, 1, 0, 0};
  localparam logic [31:0] EMASK [6] = '{32'h3, 32'hC, 32'hFF, 32'hC000_0000, 32'h3000_0000, 32'h30};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_on = 1'b0;
  logic [1:0] req_id = '0;
  logic busy, done, err;
  logic [31:0] sleep_v, iso_v;
  logic [63:0] mem_v;
  logic [2:0] drst, clken, pwr;

  always #2.5 clk = ~clk;

  pd_sequencer #(.CLK_PER_US(P), .SHORT_US(SU), .LONG_US(LU)) u_pd_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_on_i(req_on), .req_id_i(req_id),
    .busy_o(busy), .done_o(done), .err_o(err), .sleep_o(sleep_v), .iso_o(iso_v),
    .mem_pd_o(mem_v), .dom_rst_o(drst), .clk_en_o(clken), .pwr_on_o(pwr));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  int cur_d = 0;
  int t_slp, t_mf, t_ml, n_mem, t_iso, t_rr, t_rf, t_clk, t_done, n_done;
  logic [31:0] p_sleep, p_iso;
  logic [63:0] p_mem;
  logic [2:0] p_rst, p_clk;

  function automatic logic iso_bit(logic [31:0] s, logic [31:0] i, int d);
    return B_SH[d] ? s[IPOS[d]] : i[IPOS[d]];
  endfunction

  task automatic clear_stamps();
    t_slp = -1; t_mf = -1; t_ml = -1; n_mem = 0; t_iso = -1;
    t_rr = -1; t_rf = -1; t_clk = -1; t_done = -1; n_done = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sleep_v[SPOS[cur_d]] != p_sleep[SPOS[cur_d]]) t_slp = cyc;
      if (iso_bit(sleep_v, iso_v, cur_d) != iso_bit(p_sleep, p_iso, cur_d)) t_iso = cyc;
      if (mem_v != p_mem) begin
        if (t_mf < 0) t_mf = cyc;
        t_ml = cyc;
        n_mem++;
      end
      if (drst[cur_d] && !p_rst[cur_d]) t_rr = cyc;
      if (!drst[cur_d] && p_rst[cur_d]) t_rf = cyc;
      if (clken[cur_d] != p_clk[cur_d]) t_clk = cyc;
      if (done) begin t_done = cyc; n_done++; end
    end
    p_sleep = sleep_v; p_iso = iso_v; p_mem = mem_v; p_rst = drst; p_clk = clken;
  end

  logic [31:0] e_sleep, e_iso;
  logic [31:0] e_mem [2];
  logic [2:0] e_clk;

  task automatic check_regs(string tag);
    chk(tag, "sleep reg", sleep_v, e_sleep);
    chk(tag, "iso reg", iso_v, e_iso);
    chk(tag, "mem reg0", mem_v[31:0], e_mem[0]);
    chk(tag, "mem reg1", mem_v[63:32], e_mem[1]);
    chk(tag, "clk enables", clken, e_clk);
    chk(tag, "resets", drst, 3'b000);
    for (int d = 0; d < 3; d++) begin
      logic ep;
      ep = B_TOP[d] ? !e_sleep[SPOS[d]] : ((e_mem[EREG[FIRST[d]]] & EMASK[FIRST[d]]) == 0);
      chk("R8", "pwr_on", pwr[d], ep);
    end
  endtask

  task automatic run_seq(int d, bit on, bit extra);
    int t0, em;
    @(negedge clk);
    clear_stamps();
    cur_d = d; req = 1'b1; req_on = on; req_id = 2'(d); t0 = cyc + 1;
    @(negedge clk);
    req = 1'b0;
    chk("R11", "busy after accept", busy, 1);
    if (extra) begin
      repeat (3) @(negedge clk);
      req = 1'b1; req_on = 1'b1; req_id = 2'd2;
      @(negedge clk);
      req = 1'b0;
    end
    while (t_done < 0 && cyc < t0 + 300) @(negedge clk);
    repeat (4) @(negedge clk);
    if (B_TOP[d]) begin
      e_sleep[SPOS[d]] = !on;
      if (B_SH[d]) e_sleep[IPOS[d]] = !on; else e_iso[IPOS[d]] = !on;
    end
    for (int e = FIRST[d]; e < FIRST[d] + CNT[d]; e++)
      e_mem[EREG[e]] = on ? (e_mem[EREG[e]] & ~EMASK[e]) : (e_mem[EREG[e]] | EMASK[e]);
    if (B_CLK[d]) e_clk[d] = on;
    em = t0 + 1 + SP + CNT[d];
    chk(on ? "R4" : "R2", "sleep edge", t_slp, B_TOP[d] ? t0 + 1 : -1);
    chk(on ? "R4" : "R2", "first mem edge", t_mf, t0 + 2 + SP);
    chk(on ? "R4" : "R2", "last mem edge", t_ml, em);
    chk("R6", "mem edge count", n_mem, CNT[d]);
    chk(on ? "R4" : "R7", "iso edge", t_iso, B_TOP[d] ? em + SP + (on ? 2 : 1) : -1);
    chk(B_RST[d] ? "R4" : "R5", "reset assert", t_rr, (on && B_RST[d]) ? em + SP + 1 : -1);
    chk(B_RST[d] ? "R4" : "R5", "reset release", t_rf, (on && B_RST[d]) ? em + SP + 3 : -1);
    chk(on ? "R4" : "R3", "clock edge", t_clk,
        !B_CLK[d] ? -1 : (on ? em + SP + 4 : em + SP + 2 + LP));
    chk(on ? "R4" : "R3", "done cycle", t_done,
        on ? em + SP + 4 : em + SP + 2 + (B_CLK[d] ? LP : 0));
    chk(extra ? "R10" : "R11", "done count", n_done, 1);
    chk("R11", "busy idle", busy, 0);
    check_regs(on ? "R6" : "R7");
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    e_sleep = '0; e_iso = '0; e_mem[0] = '0; e_mem[1] = '0; e_clk = '0;
    for (int d = 0; d < 3; d++)
      if (B_TOP[d]) begin
        e_sleep[SPOS[d]] = 1'b1;
        if (B_SH[d]) e_sleep[IPOS[d]] = 1'b1; else e_iso[IPOS[d]] = 1'b1;
      end
    for (int e = 0; e < 6; e++) e_mem[EREG[e]] = e_mem[EREG[e]] | EMASK[e];
    clear_stamps();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_regs("R1");
    chk("R1", "busy/done/err", {busy, done, err}, 3'b000);
    // R9 out-of-range id
    @(negedge clk);
    req = 1'b1; req_on = 1'b1; req_id = 2'd3;
    @(negedge clk);
    req = 1'b0;
    chk("R9", "err pulse", err, 1);
    chk("R9", "busy on bad id", busy, 0);
    @(negedge clk);
    chk("R9", "err cleared", err, 0);
    repeat (3) @(negedge clk);
    chk("R9", "no done", done, 0);
    check_regs("R9");
    // sweep both directions over all domain kinds
    run_seq(0, 1'b1, 1'b0);
    run_seq(1, 1'b1, 1'b1);
    chk("R10", "refused domain still off", pwr[2], 0);
    run_seq(2, 1'b1, 1'b0);
    run_seq(0, 1'b0, 1'b0);
    run_seq(1, 1'b0, 1'b0);
    run_seq(2, 1'b0, 1'b0);
    run_seq(2, 1'b1, 1'b1);
    run_seq(0, 1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule